// File: doc/BRIEF.md
# Small Access Transaction Splitter

This block sits between an internal master's request port and the external transaction sequencer. The master gives a start address and a byte count. The region configuration gives the port width (16 or 32 bits), whether bursts are allowed, and the burst length (four or eight port-width beats). The block works out how many bytes one external transaction can carry. When the request is larger than that, the block sends a run of external transactions. Each transaction starts where the previous one ended, and the run continues until every requested byte has been moved.

The block treats the whole run as one indivisible operation. A bus-busy flag stays high from the first transaction to the end of the last. While it is high, no grant is passed to another bus master and no new request is accepted. A request that fits in one transaction goes out unchanged as a single transaction. The master sees one completion pulse, and only after the final transaction has finished.

Top module: `txn_splitter`

## Requirements
- R1: After reset, `xt_valid`, `bus_busy`, `req_done` and `grant_out` are low and `req_ready` is high.
- R2: With bursts disabled (`cfg_burst_en`=0), each transaction carries at most the port width in bytes: 4 when `cfg_port32`=1, 2 when `cfg_port32`=0. `xt_burst` is 0.
- R3: With bursts enabled, each transaction carries at most the port width times the beat count: 8 beats when `cfg_burst8`=1, 4 when 0. `xt_burst` is 1.
- R4: Every transaction except the last carries the full chunk. The last carries whatever bytes remain, so the byte sizes add up to the requested count.
- R5: The first transaction uses the request address. Each later address is the previous address plus the previous transaction's byte size.
- R6: A request of N bytes with chunk C produces exactly ceil(N/C) transactions. A request with N ≤ C produces exactly one.
- R7: `bus_busy` rises in the cycle after the request is accepted. It stays high without a gap until the cycle after the last `xt_done`, and then falls.
- R8: `grant_out` equals `grant_req` only when `ext_master_mode`=1 and `bus_busy`=0. Otherwise it is 0.
- R9: `req_done` is a single-cycle pulse in the cycle after the last `xt_done`.
- R10: While `xt_valid` is high and `xt_ready` is low, `xt_valid`, `xt_addr`, `xt_bytes` and `xt_burst` hold their values.
- R11: `req_ready` is low while `bus_busy` is high or a grant is being given. A request is accepted only in a cycle with `req_valid` and `req_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Master request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Start byte address |
| req_bytes | input | CW | Byte count, nonzero |
| cfg_port32 | input | 1 | 1 selects a 32-bit port, 0 a 16-bit port |
| cfg_burst_en | input | 1 | Bursts allowed |
| cfg_burst8 | input | 1 | 1 selects eight beats per burst, 0 four |
| req_done | output | 1 | Whole request finished (one-cycle pulse) |
| xt_valid | output | 1 | External transaction offered |
| xt_ready | input | 1 | Sequencer takes the transaction |
| xt_addr | output | AW | Transaction start address |
| xt_bytes | output | 6 | Bytes in this transaction |
| xt_burst | output | 1 | Transaction is a burst |
| xt_done | input | 1 | Sequencer finished the transaction |
| ext_master_mode | input | 1 | Other bus masters are present |
| grant_req | input | 1 | Another master asks for the bus |
| grant_out | output | 1 | Bus granted to the other master |
| bus_busy | output | 1 | Bus held for the current run |

## Verification
The split logic is driven with byte counts that are smaller than one chunk, exact multiples of a chunk, and that leave a remainder, under every combination of port width, burst enable and burst length. The smaller-than-one-chunk cases tell pass-through apart from splitting. Each case checks every transaction's address and byte size, so a wrong chunk, a wrong address step or a wrong final remainder shows up. While each run is in progress, the bench holds `grant_req` high and delays `xt_ready`, which exposes any gap in the bus hold, any leaked grant and any change on the offered transaction. A final case runs in internal mode to show that the grant is held off there even when the bus is idle.

// File: rtl/txn_splitter.sv
module txn_splitter #(
  parameter int AW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_bytes,
  input  logic          cfg_port32,
  input  logic          cfg_burst_en,
  input  logic          cfg_burst8,
  output logic          req_done,
  output logic          xt_valid,
  input  logic          xt_ready,
  output logic [AW-1:0] xt_addr,
  output logic [5:0]    xt_bytes,
  output logic          xt_burst,
  input  logic          xt_done,
  input  logic          ext_master_mode,
  input  logic          grant_req,
  output logic          grant_out,
  output logic          bus_busy
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  logic          p32_q, ben_q, b8_q;
  logic [5:0]    chunk;
  logic [CW-1:0] chunk_w, cur;
  logic          accept;

  assign chunk   = ben_q ? (p32_q ? (b8_q ? 6'd32 : 6'd16) : (b8_q ? 6'd16 : 6'd8))
                         : (p32_q ? 6'd4 : 6'd2);
  assign chunk_w = CW'(chunk);
  assign cur     = (rem_q < chunk_w) ? rem_q : chunk_w;

  assign bus_busy  = (st == S_ISSUE) || (st == S_WAIT);
  assign grant_out = ext_master_mode && grant_req && !bus_busy;
  assign req_ready = (st == S_IDLE || st == S_DONE) && !grant_out;
  assign accept    = req_valid && req_ready;
  assign req_done  = (st == S_DONE);
  assign xt_valid  = (st == S_ISSUE);
  assign xt_addr   = addr_q;
  assign xt_bytes  = cur[5:0];
  assign xt_burst  = ben_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      p32_q  <= 1'b0;
      ben_q  <= 1'b0;
      b8_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (accept) begin
            st     <= S_ISSUE;
            addr_q <= req_addr;
            rem_q  <= req_bytes;
            p32_q  <= cfg_port32;
            ben_q  <= cfg_burst_en;
            b8_q   <= cfg_burst8;
          end else begin
            st <= S_IDLE;
          end
        end
        S_ISSUE: if (xt_ready) begin
          st     <= S_WAIT;
          addr_q <= addr_q + AW'(cur);
          rem_q  <= rem_q - cur;
        end
        S_WAIT: if (xt_done) st <= (rem_q == '0) ? S_DONE : S_ISSUE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module txn_splitter_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          req_done,
  input logic          xt_valid,
  input logic          xt_ready,
  input logic [AW-1:0] xt_addr,
  input logic [5:0]    xt_bytes,
  input logic          xt_burst,
  input logic          grant_out,
  input logic          bus_busy
);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xt_valid && !xt_ready |=> xt_valid && $stable(xt_addr) && $stable(xt_bytes) && $stable(xt_burst));
  assert_no_grant_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !grant_out);
  assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> req_done);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);
  assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !req_ready);
  assert_size_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xt_valid |-> (xt_bytes != 6'd0) && (xt_bytes <= 6'd32) && bus_busy);
  assert_single_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xt_valid && !xt_burst |-> xt_bytes <= 6'd4);
endmodule

bind txn_splitter txn_splitter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_done(req_done),
  .xt_valid(xt_valid), .xt_ready(xt_ready), .xt_addr(xt_addr), .xt_bytes(xt_bytes),
  .xt_burst(xt_burst), .grant_out(grant_out), .bus_busy(bus_busy)
);

// File: tb/txn_splitter_tb.sv
module txn_splitter_tb;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready, cfg_port32 = 0, cfg_burst_en = 0, cfg_burst8 = 0;
  logic [31:0] req_addr = 0, xt_addr;
  logic [7:0]  req_bytes = 0;
  logic        req_done, xt_valid, xt_ready = 0, xt_burst, xt_done = 0;
  logic [5:0]  xt_bytes;
  logic        ext_master_mode = 0, grant_req = 0, grant_out, bus_busy;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  txn_splitter u_dut (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 xt_valid", xt_valid, 0);
    chk("R1 bus_busy", bus_busy, 0);
    chk("R1 req_done", req_done, 0);
    chk("R1 grant_out", grant_out, 0);
    chk("R1 req_ready", req_ready, 1);
  endtask

  task automatic run_case(input int nb, input logic [31:0] a, input logic p32,
                          input logic ben, input logic b8, input logic ext);
    int c, rem, k, ntx;
    logic [31:0] ea;
    c = (p32 ? 4 : 2) * (ben ? (b8 ? 8 : 4) : 1);
    rem = nb; ea = a; ntx = 0;
    ext_master_mode = ext; grant_req = 0;
    req_addr = a; req_bytes = 8'(nb); cfg_port32 = p32; cfg_burst_en = ben; cfg_burst8 = b8;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0; grant_req = 1;
    while (rem > 0) begin
      k = (rem < c) ? rem : c;
      chk("R7 busy during run", bus_busy, 1);
      chk("R8 no grant while busy", grant_out, 0);
      chk("R11 not ready while busy", req_ready, 0);
      chk("R10 xt_valid offered", xt_valid, 1);
      chk("R5 address", xt_addr, ea);
      chk(ben ? "R3 burst size" : "R2 single size", xt_bytes, k);
      chk("R4 remainder/chunk", xt_bytes, k);
      chk(ben ? "R3 burst flag" : "R2 burst flag", xt_burst, ben);
      @(negedge clk);
      chk("R10 held valid", xt_valid, 1);
      chk("R10 held addr", xt_addr, ea);
      chk("R10 held bytes", xt_bytes, k);
      xt_ready = 1;
      @(negedge clk);
      xt_ready = 0;
      ntx++;
      chk("R10 valid drops after take", xt_valid, 0);
      chk("R7 busy while waiting", bus_busy, 1);
      chk("R9 no early done", req_done, 0);
      @(negedge clk);
      chk("R7 busy between", bus_busy, 1);
      xt_done = 1;
      @(negedge clk);
      xt_done = 0;
      ea = ea + 32'(k); rem = rem - k;
    end
    chk("R6 transaction count", ntx, (nb + c - 1) / c);
    chk("R9 done pulse", req_done, 1);
    chk("R7 busy falls", bus_busy, 0);
    chk("R8 grant after run", grant_out, ext);
    chk("R10 no offer after run", xt_valid, 0);
    @(negedge clk);
    chk("R9 done single", req_done, 0);
    chk("R8 grant idle", grant_out, ext);
    chk("R11 ready vs grant", req_ready, !ext);
    grant_req = 0;
    @(negedge clk);
    chk("R11 ready idle", req_ready, 1);
  endtask

  task automatic test_internal_grant();
    ext_master_mode = 0; grant_req = 1;
    @(negedge clk);
    chk("R8 no grant internal", grant_out, 0);
    ext_master_mode = 1;
    @(negedge clk);
    chk("R8 grant external idle", grant_out, 1);
    req_valid = 1; req_bytes = 8'd4; req_addr = 32'h40;
    @(negedge clk);
    req_valid = 0;
    chk("R11 request blocked by grant", xt_valid, 0);
    chk("R11 still idle", bus_busy, 0);
    grant_req = 0; ext_master_mode = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    run_case(4, 32'h100, 1, 0, 0, 1);
    run_case(10, 32'h200, 1, 0, 0, 1);
    run_case(7, 32'h300, 0, 0, 0, 0);
    run_case(40, 32'h1000, 1, 1, 0, 1);
    run_case(64, 32'h2000, 1, 1, 1, 1);
    run_case(20, 32'h3000, 0, 1, 1, 0);
    run_case(12, 32'h4000, 0, 1, 0, 1);
    run_case(3, 32'h5000, 1, 1, 1, 0);
    run_case(1, 32'h6001, 0, 0, 0, 1);
    test_internal_grant();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule